// File: doc/BRIEF.md
# Synchronous Total Power Integrator

This block measures noise power with a switched calibration source. A voltage-to-frequency converter produces a pulse stream whose rate follows the detected power. The block counts the rising edges of that stream in two channels. Channel A counts while the calibration control (`sync_in`) is low, and channel B counts while it is high. The difference between the two totals tracks the excess power from the calibration source. Each channel has a prescaler whose ratio comes from a 6-bit code. The prescaler feeds a 16-bit accumulator that saturates, and the accumulator feeds a 16-bit holding register that is read at the ports.

An integration ends when `blank_in` is raised. Counting stops while `blank_in` is high. While it stays high, the first rising edge of `sync_in` copies both accumulators into the holding registers. The second rising edge clears the accumulators and the prescalers, so the next integration starts from zero when `blank_in` falls. All three asynchronous inputs pass through two-flop synchronizers before use.

Top module: `tp_integrator`

## Requirements
- R1: The prescaler ratio is (div_code[4:0] + 1), doubled when div_code[5] is 1. The ratio therefore ranges from 1 to 64.
- R2: Rising edges of `vf_pulse` are counted by channel A (`reg_a`) while `sync_in` is 0, and by channel B (`reg_b`) while `sync_in` is 1.
- R3: Every ratio-th counted edge of a channel increments that channel's accumulator by one. Edges left over stay in the prescaler.
- R4: An accumulator stops at 61441 and holds that value however many further edges arrive.
- R5: Edges of `vf_pulse` that arrive while `blank_in` is 1 are not counted by either channel.
- R6: While `blank_in` is 1, the first rising edge of `sync_in` copies each accumulator into its holding register (`reg_a`, `reg_b`).
- R7: While `blank_in` is 1, the second rising edge of `sync_in` clears both accumulators and both prescalers.
- R8: At every other time the holding registers keep their value. This includes rising edges of `sync_in` while `blank_in` is 0.
- R9: A third or later rising edge of `sync_in` in the same `blank_in` window has no effect. The edge count starts again from zero when `blank_in` returns to 0.
- R10: After reset, both holding registers, both accumulators and both prescalers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vf_pulse | input | 1 | Converter pulse stream, asynchronous |
| sync_in | input | 1 | Calibration state: 0 selects channel A, 1 selects channel B; asynchronous |
| blank_in | input | 1 | Integration stop and transfer window, asynchronous |
| div_code | input | 6 | Prescaler code: bits 4..0 give the ratio minus one, bit 5 doubles the ratio |
| reg_a | output | 16 | Holding register of channel A |
| reg_b | output | 16 | Holding register of channel B |

## Verification
The accumulators and prescalers cannot be seen directly at the ports. A fault in either one shows up in `reg_a` or `reg_b` at the next transfer, about four clocks after the first `sync_in` edge inside a blank window. A prescaler that is not cleared, or that was set up with the wrong ratio, shifts the next transferred count by one or more. A wrong edge count in the window sequencer shows up as a register that reloads zero on a third edge, or that fails to load on the first edge of a later window. The same fault appears if a `sync_in` edge outside the window is allowed to load. The saturation ceiling shows up only after more than 61441 prescaled edges.

// File: rtl/tpi_pkg.sv
package tpi_pkg;
  localparam int unsigned TPI_ACC_W   = 16;
  localparam int unsigned TPI_CEIL    = 61441;
  localparam int unsigned TPI_CODE_W  = 6;
  localparam int unsigned TPI_N_CHAN  = 2;
  localparam int unsigned TPI_SYNC_ST = 2;
endpackage

// File: rtl/tpi_sync.sv
module tpi_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d_in[b]};
    end
    assign q_out[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/tpi_prescaler.sv
module tpi_prescaler #(
  parameter int unsigned CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic              step,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int unsigned BASE_W = CODE_W - 1;
  localparam int unsigned CNT_W  = CODE_W + 1;

  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] ratio;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    base  = CNT_W'(code[BASE_W-1:0]) + CNT_W'(1);
    ratio = code[CODE_W-1] ? (base << 1) : base;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (en && step) begin
        if (cnt >= ratio - CNT_W'(1)) begin
          cnt  <= '0;
          tick <= 1'b1;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  // R5: a disabled prescaler does not move
  assert_freeze_R5: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(cnt));

  // R3: a tick only follows a counted edge
  assert_tick_src_R3: assert property (@(posedge clk) disable iff (rst)
    tick |-> $past(en && step));
endmodule

// File: rtl/tpi_channel.sv
module tpi_channel #(
  parameter int unsigned ACC_W = 16,
  parameter int unsigned CEIL  = 61441
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic             clr,
  output logic [ACC_W-1:0] hold
);
  localparam logic [ACC_W-1:0] CEIL_V = ACC_W'(CEIL);

  logic [ACC_W-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst || clr)                 acc <= '0;
    else if (tick && acc != CEIL_V) acc <= acc + ACC_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)       hold <= '0;
    else if (load) hold <= acc;
  end

  assert_ceiling_R4: assert property (@(posedge clk) disable iff (rst)
    (acc == CEIL_V && !clr) |=> acc == CEIL_V);

  assert_cleared_R7: assert property (@(posedge clk) disable iff (rst)
    clr |=> acc == '0);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(hold));
endmodule

// File: rtl/tpi_window.sv
module tpi_window (
  input  logic clk,
  input  logic rst,
  input  logic blank,
  input  logic sync_rise,
  output logic load,
  output logic clr
);
  typedef enum logic [1:0] {W_IDLE, W_LOADED, W_DONE} wstate_t;
  wstate_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= W_IDLE;
      load <= 1'b0;
      clr  <= 1'b0;
    end else begin
      load <= 1'b0;
      clr  <= 1'b0;
      if (!blank) begin
        st <= W_IDLE;
      end else if (sync_rise) begin
        case (st)
          W_IDLE:   begin load <= 1'b1; st <= W_LOADED; end
          W_LOADED: begin clr  <= 1'b1; st <= W_DONE;   end
          default:  st <= W_DONE;
        endcase
      end
    end
  end

  assert_single_action_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({load, clr}));

  assert_no_load_open_R8: assert property (@(posedge clk) disable iff (rst)
    !blank |=> !load);
endmodule

// File: rtl/tp_integrator.sv
module tp_integrator
  import tpi_pkg::*;
#(
  parameter int unsigned ACC_W  = TPI_ACC_W,
  parameter int unsigned CEIL   = TPI_CEIL,
  parameter int unsigned CODE_W = TPI_CODE_W,
  parameter int unsigned STAGES = TPI_SYNC_ST
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vf_pulse,
  input  logic              sync_in,
  input  logic              blank_in,
  input  logic [CODE_W-1:0] div_code,
  output logic [ACC_W-1:0]  reg_a,
  output logic [ACC_W-1:0]  reg_b
);
  localparam int unsigned NCH = TPI_N_CHAN;

  logic [2:0] raw_in, syn;
  logic vf_s, sync_s, blank_s;
  logic vf_d, sync_d;
  logic vf_rise, sync_rise;
  logic do_load, do_clr;
  logic [ACC_W-1:0] hold_w [NCH];

  assign raw_in = {blank_in, sync_in, vf_pulse};

  tpi_sync #(.WIDTH(3), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_in(raw_in), .q_out(syn)
  );

  assign vf_s    = syn[0];
  assign sync_s  = syn[1];
  assign blank_s = syn[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      vf_d   <= 1'b0;
      sync_d <= 1'b0;
    end else begin
      vf_d   <= vf_s;
      sync_d <= sync_s;
    end
  end

  assign vf_rise   = vf_s & ~vf_d;
  assign sync_rise = sync_s & ~sync_d;

  tpi_window u_window (
    .clk(clk), .rst(rst), .blank(blank_s), .sync_rise(sync_rise),
    .load(do_load), .clr(do_clr)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic gate_en;
    logic tick;
    assign gate_en = !blank_s && (sync_s == c[0]);

    tpi_prescaler #(.CODE_W(CODE_W)) u_pre (
      .clk(clk), .rst(rst), .clr(do_clr), .en(gate_en), .step(vf_rise),
      .code(div_code), .tick(tick)
    );

    tpi_channel #(.ACC_W(ACC_W), .CEIL(CEIL)) u_acc (
      .clk(clk), .rst(rst), .tick(tick), .load(do_load), .clr(do_clr),
      .hold(hold_w[c])
    );
  end

  assign reg_a = hold_w[0];
  assign reg_b = hold_w[1];
endmodule

// File: tb/tb_tp_integrator.sv
module tb_tp_integrator;
  localparam int CEIL = 61441;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vf_pulse = 1'b0;
  logic sync_in = 1'b0;
  logic blank_in = 1'b0;
  logic [5:0] div_code = 6'd0;
  logic [15:0] reg_a, reg_b;

  always #5 clk = ~clk;

  tp_integrator dut (
    .clk(clk), .rst(rst), .vf_pulse(vf_pulse), .sync_in(sync_in),
    .blank_in(blank_in), .div_code(div_code), .reg_a(reg_a), .reg_b(reg_b)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_pc [2];
  int m_acc [2];
  int m_reg [2];
  int m_sync = 0;
  int m_blank = 0;
  int m_scnt = 0;

  // {code[5:0], pulses on A, pulses on B}
  localparam logic [21:0] VEC [7] = '{
    {6'h00, 8'd5,   8'd0},
    {6'h03, 8'd0,   8'd10},
    {6'h21, 8'd9,   8'd7},
    {6'h1F, 8'd70,  8'd33},
    {6'h3F, 8'd200, 8'd130},
    {6'h25, 8'd25,  8'd12},
    {6'h20, 8'd7,   8'd3}
  };

  function automatic int ratio_of(input logic [5:0] c);
    int r;
    r = int'(c[4:0]) + 1;
    if (c[5]) r = r * 2;
    return r;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      vf_pulse = 1'b1;
      wait_n(1);
      vf_pulse = 1'b0;
      wait_n(1);
      if (m_blank == 0) begin
        m_pc[m_sync]++;
        if (m_pc[m_sync] >= ratio_of(div_code)) begin
          m_pc[m_sync] = 0;
          if (m_acc[m_sync] < CEIL) m_acc[m_sync]++;
        end
      end
    end
    wait_n(6);
  endtask

  task automatic set_sync(input int v);
    sync_in = v[0];
    m_sync = v;
    wait_n(6);
  endtask

  task automatic sync_pulse();
    sync_in = 1'b1;
    wait_n(6);
    if (m_blank != 0) begin
      if (m_scnt == 0) begin
        m_reg[0] = m_acc[0];
        m_reg[1] = m_acc[1];
      end else if (m_scnt == 1) begin
        m_acc[0] = 0; m_acc[1] = 0;
        m_pc[0] = 0;  m_pc[1] = 0;
      end
      if (m_scnt < 3) m_scnt++;
    end
    sync_in = 1'b0;
    wait_n(6);
  endtask

  task automatic raise_blank();
    blank_in = 1'b1;
    m_blank = 1;
    m_scnt = 0;
    wait_n(6);
  endtask

  task automatic drop_blank();
    blank_in = 1'b0;
    m_blank = 0;
    m_scnt = 0;
    wait_n(6);
  endtask

  task automatic full_seq(input string req);
    set_sync(0);
    raise_blank();
    sync_pulse();
    check({req, " R6 reg_a"}, int'(reg_a), m_reg[0]);
    check({req, " R6 reg_b"}, int'(reg_b), m_reg[1]);
    sync_pulse();
    drop_blank();
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R2 actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      m_pc[c] = 0; m_acc[c] = 0; m_reg[c] = 0;
    end
    wait_n(4);
    rst = 1'b0;
    wait_n(2);
    // R10 reset state
    check("R10 reg_a after reset", int'(reg_a), 0);
    check("R10 reg_b after reset", int'(reg_b), 0);

    // R1 R2 R3 table of codes and channel pulse counts
    for (int v = 0; v < 7; v++) begin
      div_code = VEC[v][21:16];
      wait_n(2);
      set_sync(0);
      pulses(int'(VEC[v][15:8]));
      set_sync(1);
      pulses(int'(VEC[v][7:0]));
      full_seq("R1 R2 R3 vector");
    end

    // R8: counting and open-window sync edges leave registers unchanged
    div_code = 6'h00;
    wait_n(2);
    pulses(4);
    set_sync(1);
    set_sync(0);
    check("R8 reg_a held", int'(reg_a), m_reg[0]);
    check("R8 reg_b held", int'(reg_b), m_reg[1]);
    pulses(3);

    // R5: edges inside blank are ignored
    raise_blank();
    pulses(5);
    drop_blank();
    full_seq("R5 blank freeze");
    check("R5 reg_a excludes blanked edges", int'(reg_a), 7);

    // R9: third edge does nothing, window restarts after blank drops
    pulses(6);
    raise_blank();
    sync_pulse();
    sync_pulse();
    sync_pulse();
    check("R9 third edge reg_a", int'(reg_a), 6);
    drop_blank();
    pulses(2);
    raise_blank();
    sync_pulse();
    check("R9 restart reg_a", int'(reg_a), 2);
    sync_pulse();
    drop_blank();

    // R7: clear also empties the prescaler
    div_code = 6'h03;
    wait_n(2);
    pulses(3);
    full_seq("R7 pre");
    pulses(1);
    full_seq("R7 prescaler cleared");
    check("R7 reg_a", int'(reg_a), 0);

    // R4 saturation
    div_code = 6'h00;
    wait_n(2);
    pulses(CEIL + 4);
    full_seq("R4 saturation");
    check("R4 reg_a at ceiling", int'(reg_a), CEIL);
    check("R4 reg_b untouched", int'(reg_b), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule